// File: doc/BRIEF.md
# Page Translation Buffer with Access Checking

This block is a small, fully associative store of recent page translations. A request carries a virtual address, an access kind (load, store or instruction fetch) and a privilege flag. In the same cycle the block compares the virtual page number against every stored tag. On a match it returns the physical address, which is the stored frame number joined to the untouched page offset. It also checks the request against the permission bits of the matching entry. A denied access raises a fault, and the address is then not flagged as usable.

When no entry matches, the block signals a miss so that an external table walker can fetch the mapping and load it through the refill port. The walker's page-table format and the handling of faults belong to other blocks. Each entry keeps a referenced flag and a modified flag, and the block updates both itself. It reports the stored values of these flags on every hit, so the walker or the operating system can write them back. Placement prefers an empty slot and otherwise evicts the least recently used one. A flush input empties the whole store in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: With `req_valid` high and no valid entry whose tag equals the request's page number, `miss` is 1 and `hit` is 0. With `req_valid` low, both are 0. At most one entry ever matches.
- R2: On a hit, `paddr` equals the entry's frame number concatenated with the low OFF_W bits of `req_vaddr`, in the same cycle as the request.
- R3: Permission bits are {user, exec, write, read} = `refill_perm[3:0]`. Access codes are 0 load (needs read), 1 store (needs write), 2 fetch (needs exec), and 3 reserved (always denied). With `req_user` = 1 the user bit must also be set. Supervisor requests ignore the user bit.
- R4: A hit whose access is denied drives `prot_fault` = 1 and `paddr_valid` = 0 with `hit` still 1. A permitted hit drives `paddr_valid` = 1 and `prot_fault` = 0.
- R5: On a hit, `ent_ref` shows the entry's stored referenced flag. Refill clears it, and any hit, permitted or not, sets it for later requests.
- R6: On a hit, `ent_dirty` shows the stored modified flag. Refill clears it. Only a permitted store hit sets it, and a denied store leaves it clear.
- R7: A refill is written into the lowest-numbered invalid entry when one exists.
- R8: With all entries valid, a refill replaces the entry whose last use is oldest. Both a hit and a refill count as a use.
- R9: `flush` invalidates every entry at the next clock edge. A refill presented in the same cycle is discarded.
- R10: In a cycle where `refill_valid` is high, a simultaneous lookup still returns its result but changes neither flags nor use order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | 1 = user-mode request |
| hit | output | 1 | A valid entry matches |
| miss | output | 1 | Request with no matching entry |
| prot_fault | output | 1 | Matching entry denies this access |
| paddr_valid | output | 1 | `paddr` may be used |
| paddr | output | PPN_W+OFF_W | Translated address |
| ent_ref | output | 1 | Stored referenced flag of the hit entry |
| ent_dirty | output | 1 | Stored modified flag of the hit entry |
| refill_valid | input | 1 | Load a new entry |
| refill_vpn | input | VPN_W | Tag of the new entry |
| refill_ppn | input | PPN_W | Frame number of the new entry |
| refill_perm | input | 4 | {user, exec, write, read} permissions |

## Verification
The bench builds the block with 4 entries, 8-bit page and frame numbers and a 4-bit offset. At this size every one of the 16 permission patterns can be loaded and probed with all four access codes in both privilege modes. Each probe checks the translated address, the fault and the progression of both flags, with expected values computed arithmetically. Four slots are few enough that a short, scripted series of touches and refills fixes a unique eviction order, which separates empty-slot placement from age-based eviction. The same bench also exercises flush priority and the suppression of updates during a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef struct packed {
      logic usr;
      logic ex;
      logic wr;
      logic rd;
   } perm_t;

   localparam int PERM_W = $bits(perm_t);

endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
(
   input  perm_t perm,
   input  acc_e  acc,
   input  logic  user,
   output logic  allow
);

   logic kind_ok;

   always_comb begin
      unique case (acc)
         ACC_LOAD:  kind_ok = perm.rd;
         ACC_STORE: kind_ok = perm.wr;
         ACC_FETCH: kind_ok = perm.ex;
         default:   kind_ok = 1'b0;
      endcase
      allow = kind_ok & (~user | perm.usr);
   end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N = 8,
   parameter int W = 20,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        valid,
   input  logic [N-1:0][W-1:0] tags,
   input  logic [W-1:0]        key,
   output logic [N-1:0]        match,
   output logic                any,
   output logic [IW-1:0]       idx
);

   if (N < 2) begin : g_bad_n
      $error("tlb_cam: N must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("tlb_cam: W must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = valid[i] & (tags[i] == key);
   end

   assign any = |match;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) idx = idx | IW'(i);
      end
   end

   AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R1

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   input  logic [N-1:0]  valid,
   output logic [IW-1:0] victim
);

   if (N < 2) begin : g_bad_n
      $error("tlb_lru: N must be at least 2");
   end

   logic [N-1:0]  oldest;
   logic [IW-1:0] oldest_idx;

   if (N == 2) begin : g_bit
      logic lru_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     lru_q <= 1'b0;
         else if (touch) lru_q <= ~touch_idx[0];
      end
      assign oldest     = {lru_q, ~lru_q};
      assign oldest_idx = lru_q;
   end else begin : g_age
      logic [N-1:0][IW-1:0] age_q;
      logic [IW-1:0]        cur_age;

      assign cur_age = age_q[touch_idx];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
         end else if (touch) begin
            for (int i = 0; i < N; i++) begin
               if (IW'(i) == touch_idx)    age_q[i] <= '0;
               else if (age_q[i] < cur_age) age_q[i] <= age_q[i] + 1'b1;
            end
         end
      end

      for (genvar i = 0; i < N; i++) begin : g_old
         assign oldest[i] = (age_q[i] == IW'(N - 1));
      end

      always_comb begin
         oldest_idx = '0;
         for (int i = 0; i < N; i++) begin
            if (oldest[i]) oldest_idx = oldest_idx | IW'(i);
         end
      end
   end

   always_comb begin
      victim = oldest_idx;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) victim = IW'(i);
      end
   end

   AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1); // R8

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int OFF_W   = 12,
   localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int VA_W   = VPN_W + OFF_W,
   localparam int PA_W   = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   input  logic             req_user,
   output logic             hit,
   output logic             miss,
   output logic             prot_fault,
   output logic             paddr_valid,
   output logic [PA_W-1:0]  paddr,
   output logic             ent_ref,
   output logic             ent_dirty,
   input  logic             refill_valid,
   input  logic [VPN_W-1:0] refill_vpn,
   input  logic [PPN_W-1:0] refill_ppn,
   input  logic [3:0]       refill_perm
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES must be at least 2");
   end
   if (OFF_W < 1 || VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("tlb_xlate: widths must be positive");
   end
   if (PERM_W != 4) begin : g_bad_perm
      $error("tlb_xlate: permission field must be 4 bits");
   end

   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0]             dirty_q;
   logic [ENTRIES-1:0]             ref_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

   logic [VPN_W-1:0]   req_vpn;
   logic [OFF_W-1:0]   req_off;
   logic [ENTRIES-1:0] match;
   logic               any_match;
   logic [IW-1:0]      hit_idx;
   logic [IW-1:0]      victim;
   logic               allow;
   logic               upd_en;
   logic               do_refill;
   logic               is_store;
   logic               lru_touch;
   logic [IW-1:0]      lru_idx;
   perm_t              sel_perm;
   acc_e               acc;

   assign req_vpn = req_vaddr[VA_W-1:OFF_W];
   assign req_off = req_vaddr[OFF_W-1:0];
   assign acc     = acc_e'(req_acc);

   tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_cam (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (valid_q),
      .tags  (tag_q),
      .key   (req_vpn),
      .match (match),
      .any   (any_match),
      .idx   (hit_idx)
   );

   assign sel_perm = perm_t'(perm_q[hit_idx]);

   tlb_perm u_perm (
      .perm  (sel_perm),
      .acc   (acc),
      .user  (req_user),
      .allow (allow)
   );

   assign hit         = req_valid & any_match;
   assign miss        = req_valid & ~any_match;
   assign prot_fault  = hit & ~allow;
   assign paddr_valid = hit & allow;
   assign paddr       = {ppn_q[hit_idx], req_off};
   assign ent_ref     = hit & ref_q[hit_idx];
   assign ent_dirty   = hit & dirty_q[hit_idx];

   assign do_refill = refill_valid & ~flush;
   assign upd_en    = hit & ~refill_valid & ~flush;
   assign is_store  = (acc == ACC_STORE);

   assign lru_touch = do_refill | upd_en;
   assign lru_idx   = do_refill ? victim : hit_idx;

   tlb_lru #(.N(ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (lru_touch),
      .touch_idx (lru_idx),
      .valid     (valid_q),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         ref_q   <= '0;
         tag_q   <= '0;
         ppn_q   <= '0;
         perm_q  <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (do_refill && victim == IW'(i)) begin
               valid_q[i] <= 1'b1;
               dirty_q[i] <= 1'b0;
               ref_q[i]   <= 1'b0;
               tag_q[i]   <= refill_vpn;
               ppn_q[i]   <= refill_ppn;
               perm_q[i]  <= refill_perm;
            end else if (upd_en && match[i]) begin
               ref_q[i] <= 1'b1;
               if (allow && is_store) dirty_q[i] <= 1'b1;
            end
         end
      end
   end

   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      prot_fault |-> (hit && !paddr_valid)); // R4

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit); // R9

   for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
      AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && match[i] && paddr_valid && acc == ACC_STORE && !refill_valid && !flush)
         |=> dirty_q[i]); // R6
      AST_REFILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
         (do_refill && victim == IW'(i)) |=> (valid_q[i] && !dirty_q[i] && !ref_q[i])); // R5
   end

endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

   localparam int NE = 4;
   localparam int VW = 8;
   localparam int PW = 8;
   localparam int OW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic req_valid = 1'b0;
   logic [VW+OW-1:0] req_vaddr = '0;
   logic [1:0] req_acc = '0;
   logic req_user = 1'b0;
   logic hit, miss, prot_fault, paddr_valid, ent_ref, ent_dirty;
   logic [PW+OW-1:0] paddr;
   logic refill_valid = 1'b0;
   logic [VW-1:0] refill_vpn = '0;
   logic [PW-1:0] refill_ppn = '0;
   logic [3:0] refill_perm = '0;

   int checks = 0;
   int errors = 0;
   logic s_hit, s_miss, s_fault, s_pv, s_ref, s_dirty;
   logic [PW+OW-1:0] s_pa;

   always #5 clk = ~clk;

   tlb_xlate #(.ENTRIES(NE), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
      .hit(hit), .miss(miss), .prot_fault(prot_fault), .paddr_valid(paddr_valid),
      .paddr(paddr), .ent_ref(ent_ref), .ent_dirty(ent_dirty),
      .refill_valid(refill_valid), .refill_vpn(refill_vpn),
      .refill_ppn(refill_ppn), .refill_perm(refill_perm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic sample();
      s_hit = hit; s_miss = miss; s_fault = prot_fault; s_pv = paddr_valid;
      s_ref = ent_ref; s_dirty = ent_dirty; s_pa = paddr;
   endtask

   task automatic look(input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                       input logic [1:0] acc, input logic usr);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {vpn, off}; req_acc = acc; req_user = usr;
      #1 sample();
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic refill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                         input logic [3:0] perm);
      @(negedge clk);
      refill_valid = 1'b1; refill_vpn = vpn; refill_ppn = ppn; refill_perm = perm;
      @(posedge clk); #1;
      refill_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk); #1;
      flush = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, idle and empty lookups
      @(negedge clk); #1;
      chk("R1 idle hit", 32'(hit), 0);
      chk("R1 idle miss", 32'(miss), 0);
      look(8'h55, 4'h3, 2'd0, 1'b0);
      chk("R1 empty miss", 32'(s_miss), 1);
      chk("R1 empty hit", 32'(s_hit), 0);

      // R2 R3 R4 R5 R6: sweep all permission patterns, access codes and modes
      for (int p = 0; p < 16; p++) begin
         logic er, ed;
         logic [PW-1:0] ppn;
         ppn = PW'(p * 7 + 3);
         refill(VW'(8'h20 + p), ppn, 4'(p));
         er = 1'b0; ed = 1'b0;
         for (int u = 0; u < 2; u++) begin
            for (int a = 0; a < 4; a++) begin
               logic [OW-1:0] off;
               logic f;
               off = OW'(p * 3 + a + u * 5);
               f = (u == 1 && ((p >> 3) & 1) == 0) || a == 3 || ((p >> a) & 1) == 0;
               look(VW'(8'h20 + p), off, 2'(a), 1'(u));
               chk("R1 sweep hit", 32'(s_hit), 1);
               chk("R3 fault", 32'(s_fault), 32'(f));
               chk("R4 paddr_valid", 32'(s_pv), 32'(!f));
               chk("R2 paddr", 32'(s_pa), 32'({ppn, off}));
               chk("R5 ref flag", 32'(s_ref), 32'(er));
               chk("R6 dirty flag", 32'(s_dirty), 32'(ed));
               er = 1'b1;
               if (a == 1 && !f) ed = 1'b1;
            end
         end
      end

      // R9: flush empties
      do_flush();
      look(8'h2F, 4'h0, 2'd0, 1'b0);
      chk("R9 miss after flush", 32'(s_miss), 1);

      // R9: flush beats a simultaneous refill
      @(negedge clk);
      flush = 1'b1; refill_valid = 1'b1; refill_vpn = 8'h77; refill_ppn = 8'h11; refill_perm = 4'hF;
      @(posedge clk); #1;
      flush = 1'b0; refill_valid = 1'b0;
      look(8'h77, 4'h0, 2'd0, 1'b0);
      chk("R9 refill dropped on flush", 32'(s_miss), 1);

      // R10: lookup during refill leaves flags unchanged
      refill(8'h40, 8'h99, 4'hF);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {8'h40, 4'h1}; req_acc = 2'd1; req_user = 1'b0;
      refill_valid = 1'b1; refill_vpn = 8'h41; refill_ppn = 8'h9A; refill_perm = 4'hF;
      #1 sample();
      chk("R10 result during refill", 32'(s_pa), 32'({8'h99, 4'h1}));
      @(posedge clk); #1;
      req_valid = 1'b0; refill_valid = 1'b0;
      look(8'h40, 4'h2, 2'd0, 1'b0);
      chk("R10 dirty untouched", 32'(s_dirty), 0);
      chk("R10 ref untouched", 32'(s_ref), 0);

      // R7: after flush, four refills all land in empty slots
      do_flush();
      for (int i = 0; i < 4; i++) refill(VW'(8'h60 + i), PW'(8'hC0 + i), 4'hF);
      for (int i = 0; i < 4; i++) begin
         look(VW'(8'h60 + i), 4'h5, 2'd0, 1'b0);
         chk("R7 kept", 32'(s_hit), 1);
         chk("R7 paddr", 32'(s_pa), 32'({8'hC0 + i, 4'h5}));
      end

      // R8: age order A,B,C,D; touch A,C -> B oldest, then D
      do_flush();
      for (int i = 0; i < 4; i++) refill(VW'(8'h80 + i), PW'(8'hD0 + i), 4'hF);
      look(8'h80, 4'h0, 2'd0, 1'b0);
      look(8'h82, 4'h0, 2'd0, 1'b0);
      refill(8'h84, 8'hD4, 4'hF);
      look(8'h81, 4'h0, 2'd0, 1'b0);
      chk("R8 oldest evicted", 32'(s_miss), 1);
      refill(8'h85, 8'hD5, 4'hF);
      look(8'h83, 4'h0, 2'd0, 1'b0);
      chk("R8 next oldest evicted", 32'(s_miss), 1);
      look(8'h80, 4'h0, 2'd0, 1'b0);
      chk("R8 touched kept A", 32'(s_hit), 1);
      look(8'h82, 4'h0, 2'd0, 1'b0);
      chk("R8 touched kept C", 32'(s_hit), 1);
      look(8'h84, 4'h7, 2'd0, 1'b0);
      chk("R8 new kept E", 32'(s_pa), 32'({8'hD4, 4'h7}));
      look(8'h85, 4'h7, 2'd0, 1'b0);
      chk("R8 new kept F", 32'(s_pa), 32'({8'hD5, 4'h7}));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule